// File: doc/BRIEF.md
# Two-Slice Byte ALU with Packed-BCD Arithmetic

This block is the arithmetic and logic unit of a small 8-bit processor. The byte data path is cut into a low and a high nibble slice. Each slice is a purely combinational function of its own two operand nibbles, a function code, a decimal enable, a carry input and a zero input. A decoder turns the 4-bit operation code into slice controls and into the routing of the carry chain. For additions, subtractions and left shifts, the carry runs from the low slice to the high slice. For right shifts it runs from the high slice to the low slice. The zero indication always runs upward, so the high slice reports zero for the whole byte.

The operand `reg_a` plays the accumulator role and is the only source for increment, decrement and the shifts and rotates. `operand_b` is the memory operand. A registered output stage captures the result byte and the four flags on a clock-enable strobe, so results appear one clock after the strobed edge and are held until the next strobe.

Top module: `split_alu`

## Requirements
- R1: While `rst_n` is low, and after the first edge with `rst_n` low, `result` is 0x00 and all four flags are 0.
- R2: Result and flags change only at a rising edge where `strobe` is 1, and they then show the operation presented at that edge. Without a strobe they hold their values.
- R3: Operation code 0 (add with carry) gives `reg_a + operand_b + carry_in`. C is the carry out of bit 7. V is set when both operands have equal bit 7 and the result's bit 7 differs from it.
- R4: Operation code 1 (subtract with borrow) gives `reg_a - operand_b - (1 - carry_in)`. C is 1 when no borrow occurred. V is set when the operands differ in bit 7 and the result's bit 7 differs from `reg_a` bit 7.
- R5: With `dec_mode` = 1, codes 0 and 1 treat each nibble as a BCD digit. Add: a digit sum above 9 is raised by 6 and carries out. Subtract: a digit that borrows is lowered by 6. The decimal carry or borrow passes from the low digit to the high digit. V is 0. `dec_mode` has no effect on any other code.
- R6: Codes 2, 3 and 4 give bitwise AND, OR and exclusive OR of the operands. C equals `carry_in` and V is 0.
- R7: Code 5 (bit test) outputs `reg_a & operand_b`. Z is set when that value is zero. N equals `operand_b` bit 7, V equals `operand_b` bit 6, and C equals `carry_in`.
- R8: Code 6 (compare) outputs `reg_a - operand_b`. C is 1 when `reg_a >= operand_b` unsigned, Z is 1 when they are equal, and V is 0. `carry_in` and `dec_mode` are ignored.
- R9: Code 7 outputs `reg_a + 1` and code 8 outputs `reg_a - 1`, both modulo 256. C equals `carry_in` and V is 0.
- R10: Codes 9 (shift left) and 11 (rotate left) move `reg_a` up one bit, with nibble bit 3 entering bit 4. Bit 0 becomes 0 for code 9 and `carry_in` for code 11. C is the old bit 7. V is 0.
- R11: Codes 10 (shift right) and 12 (rotate right) move `reg_a` down one bit, with bit 4 entering bit 3. Bit 7 becomes 0 for code 10 and `carry_in` for code 12. C is the old bit 0. V is 0.
- R12: For every code except 5, Z is 1 exactly when all eight result bits are 0. A zero low nibble alone does not set it.
- R13: For every code except 5, N equals result bit 7. Codes 13 to 15 pass `reg_a` through with C equal to `carry_in` and V 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe | input | 1 | Capture enable for result and flags |
| op | input | 4 | Operation code (0..12 defined, 13..15 pass-through) |
| dec_mode | input | 1 | Packed-BCD mode for add and subtract |
| carry_in | input | 1 | Carry flag value entering the operation |
| reg_a | input | 8 | Accumulator-side operand |
| operand_b | input | 8 | Memory-side operand |
| result | output | 8 | Registered result byte |
| flag_c | output | 1 | Registered carry flag |
| flag_z | output | 1 | Registered zero flag |
| flag_v | output | 1 | Registered overflow flag |
| flag_n | output | 1 | Registered negative flag |

## Verification
In the risky cycles, a decimal adjustment in both slices coincides with a carry crossing the nibble boundary. A 99 plus 01 in decimal mode is one example: it adjusts both digits, ripples the decimal carry into the high slice and must raise Z from the chained zero in the same strobe. Decimal borrows through 00 are another case of the same kind. The bench forces these coincidences with table vectors chosen so that both slices adjust together. It also sends a stream of random valid-BCD operands through a behavioural model that computes each digit separately. It judges the registered byte and all four flags together, one clock after the strobe. Right-shift vectors with bit 4 set play the same role for the reversed carry direction.

// File: rtl/split_alu_pkg.sv
// Shared types for the two-slice ALU: operation codes, slice functions,
// carry-source selectors and the decoded control word.
// Assumes a byte built from exactly two nibble slices.
package split_alu_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;
    localparam int FLAG_W = 4;

    typedef enum logic [3:0] {
        OP_ADC = 4'd0,
        OP_SBC = 4'd1,
        OP_AND = 4'd2,
        OP_ORA = 4'd3,
        OP_EOR = 4'd4,
        OP_BIT = 4'd5,
        OP_CMP = 4'd6,
        OP_INC = 4'd7,
        OP_DEC = 4'd8,
        OP_ASL = 4'd9,
        OP_LSR = 4'd10,
        OP_ROL = 4'd11,
        OP_ROR = 4'd12
    } alu_op_e;

    typedef enum logic [2:0] {
        FN_ADD, FN_SUB, FN_AND, FN_OR, FN_EOR, FN_SHL, FN_SHR, FN_PASS
    } slice_fn_e;

    typedef enum logic [1:0] {
        CI_FLAG, CI_ZERO, CI_ONE, CI_PEER
    } cin_src_e;

    typedef enum logic [1:0] {
        CO_HIGH, CO_LOW, CO_KEEP
    } cout_src_e;

    typedef struct packed {
        slice_fn_e fn;
        cin_src_e  lo_src;
        cin_src_e  hi_src;
        cout_src_e co_src;
        logic      b_zero;
        logic      dec_en;
        logic      v_en;
        logic      bit_mode;
    } alu_ctrl_t;

endpackage

// File: rtl/split_alu_decode.sv
// Operation decoder: maps a 4-bit operation code onto slice function,
// carry routing per slice, final carry source and flag qualifiers.
// Assumes undefined codes behave as a pass-through of the A operand.
module split_alu_decode
    import split_alu_pkg::*;
(
    input  logic [3:0] op,
    output alu_ctrl_t  ctrl
);

    // Purpose: one control word per operation code.
    always_comb begin
        ctrl = '{fn: FN_PASS, lo_src: CI_ZERO, hi_src: CI_PEER,
                 co_src: CO_KEEP, b_zero: 1'b0, dec_en: 1'b0,
                 v_en: 1'b0, bit_mode: 1'b0};
        case (op)
            OP_ADC: begin
                ctrl.fn = FN_ADD; ctrl.lo_src = CI_FLAG; ctrl.co_src = CO_HIGH;
                ctrl.dec_en = 1'b1; ctrl.v_en = 1'b1;
            end
            OP_SBC: begin
                ctrl.fn = FN_SUB; ctrl.lo_src = CI_FLAG; ctrl.co_src = CO_HIGH;
                ctrl.dec_en = 1'b1; ctrl.v_en = 1'b1;
            end
            OP_CMP: begin
                ctrl.fn = FN_SUB; ctrl.lo_src = CI_ONE; ctrl.co_src = CO_HIGH;
            end
            OP_INC: begin
                ctrl.fn = FN_ADD; ctrl.lo_src = CI_ONE; ctrl.b_zero = 1'b1;
            end
            OP_DEC: begin
                ctrl.fn = FN_SUB; ctrl.lo_src = CI_ZERO; ctrl.b_zero = 1'b1;
            end
            OP_AND: ctrl.fn = FN_AND;
            OP_ORA: ctrl.fn = FN_OR;
            OP_EOR: ctrl.fn = FN_EOR;
            OP_BIT: begin
                ctrl.fn = FN_AND; ctrl.bit_mode = 1'b1;
            end
            OP_ASL: begin
                ctrl.fn = FN_SHL; ctrl.lo_src = CI_ZERO; ctrl.co_src = CO_HIGH;
            end
            OP_ROL: begin
                ctrl.fn = FN_SHL; ctrl.lo_src = CI_FLAG; ctrl.co_src = CO_HIGH;
            end
            OP_LSR: begin
                ctrl.fn = FN_SHR; ctrl.lo_src = CI_PEER; ctrl.hi_src = CI_ZERO;
                ctrl.co_src = CO_LOW;
            end
            OP_ROR: begin
                ctrl.fn = FN_SHR; ctrl.lo_src = CI_PEER; ctrl.hi_src = CI_FLAG;
                ctrl.co_src = CO_LOW;
            end
            default: ctrl.fn = FN_PASS;
        endcase
    end

endmodule

// File: rtl/split_alu_slice.sv
// One nibble slice: combinational result, carry out, chained zero and,
// in the high variant, negative and overflow. The carry input carries
// add carry, not-borrow, or the bit shifted in, depending on function.
// peer_out feeds the other slice: carry out upward (low variant) or the
// bit shifted downward (high variant), so no path loops through cin.
module split_alu_slice
    import split_alu_pkg::*;
#(
    parameter bit HIGH = 1'b0
) (
    input  logic [NIB_W-1:0] a,
    input  logic [NIB_W-1:0] b,
    input  slice_fn_e        fn,
    input  logic             dec,
    input  logic             v_en,
    input  logic             bit_mode,
    input  logic             cin,
    input  logic             zin,
    output logic [NIB_W-1:0] y,
    output logic             cout,
    output logic             zout,
    output logic             peer_out,
    output logic             n,
    output logic             v
);

    localparam logic [NIB_W:0] DIGIT_MAX = (NIB_W+1)'(9);
    localparam logic [NIB_W:0] DIGIT_ADJ = (NIB_W+1)'(6);

    logic [NIB_W:0]   t;
    logic [NIB_W-1:0] b_eff;

    // Purpose: nibble arithmetic, logic and shift with decimal correction.
    always_comb begin
        t     = '0;
        y     = a;
        cout  = 1'b0;
        b_eff = (fn == FN_SUB) ? ~b : b;
        case (fn)
            FN_ADD: begin
                t = {1'b0, a} + {1'b0, b} + {{NIB_W{1'b0}}, cin};
                if (dec && (t > DIGIT_MAX)) begin
                    t    = t + DIGIT_ADJ;
                    cout = 1'b1;
                end else begin
                    cout = t[NIB_W];
                end
                y = t[NIB_W-1:0];
            end
            FN_SUB: begin
                t    = {1'b0, a} + {1'b0, b_eff} + {{NIB_W{1'b0}}, cin};
                cout = t[NIB_W];
                y    = (dec && !t[NIB_W]) ? (t[NIB_W-1:0] - DIGIT_ADJ[NIB_W-1:0])
                                          : t[NIB_W-1:0];
            end
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_EOR:  y = a ^ b;
            FN_SHL: begin
                y    = {a[NIB_W-2:0], cin};
                cout = a[NIB_W-1];
            end
            FN_SHR: begin
                y    = {cin, a[NIB_W-1:1]};
                cout = a[0];
            end
            default: y = a;
        endcase
    end

    // Purpose: zero chain from the lower slice.
    assign zout = zin & (y == '0);

    generate
        if (HIGH) begin : g_high
            // Purpose: byte-level sign and overflow, bit-test source select.
            assign n        = bit_mode ? b[NIB_W-1] : y[NIB_W-1];
            assign v        = bit_mode ? b[NIB_W-2]
                                       : (v_en & (a[NIB_W-1] == b_eff[NIB_W-1])
                                               & (y[NIB_W-1] != a[NIB_W-1]));
            assign peer_out = a[0];
        end else begin : g_low
            // Purpose: low slice reports no sign; passes its carry upward.
            assign n        = 1'b0;
            assign v        = 1'b0;
            assign peer_out = cout;
        end
    endgenerate

endmodule

// File: rtl/split_alu_flop.sv
// Output stage: a W-bit register with synchronous active-low reset
// and a load enable. Holds its value whenever the enable is low.
module split_alu_flop #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Purpose: capture on enable, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
    end

endmodule

// File: rtl/split_alu.sv
// Top: byte ALU from two nibble slices. Routes carries upward for add,
// subtract and left shifts, downward for right shifts, chains zero
// upward, and registers result and flags on the strobe.
// Assumes dec_mode only affects add and subtract with carry.
module split_alu
    import split_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [3:0]        op,
    input  logic              dec_mode,
    input  logic              carry_in,
    input  logic [BYTE_W-1:0] reg_a,
    input  logic [BYTE_W-1:0] operand_b,
    output logic [BYTE_W-1:0] result,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_n
);

    localparam int REG_W = BYTE_W + FLAG_W;

    alu_ctrl_t         ctrl;
    logic [BYTE_W-1:0] b_in;
    logic              dec_on;
    logic              lo_cin, hi_cin;
    logic [NIB_W-1:0]  lo_y, hi_y;
    logic              lo_cout, hi_cout, lo_z, hi_z;
    logic              lo_peer, hi_peer;
    logic              lo_n, lo_v, hi_n, hi_v;
    logic              c_next;
    logic [REG_W-1:0]  d_pack, q_pack;

    // Purpose: pick a slice carry input from its selector.
    function automatic logic pick_cin(cin_src_e src, logic flag, logic peer);
        case (src)
            CI_FLAG: return flag;
            CI_ONE:  return 1'b1;
            CI_PEER: return peer;
            default: return 1'b0;
        endcase
    endfunction

    split_alu_decode u_decode (
        .op   (op),
        .ctrl (ctrl)
    );

    // Purpose: operand gating and carry routing between slices.
    assign b_in   = ctrl.b_zero ? '0 : operand_b;
    assign dec_on = ctrl.dec_en & dec_mode;
    assign lo_cin = pick_cin(ctrl.lo_src, carry_in, hi_peer);
    assign hi_cin = pick_cin(ctrl.hi_src, carry_in, lo_peer);

    split_alu_slice #(.HIGH(1'b0)) u_lo (
        .a        (reg_a[NIB_W-1:0]),
        .b        (b_in[NIB_W-1:0]),
        .fn       (ctrl.fn),
        .dec      (dec_on),
        .v_en     (ctrl.v_en & ~dec_on),
        .bit_mode (ctrl.bit_mode),
        .cin      (lo_cin),
        .zin      (1'b1),
        .y        (lo_y),
        .cout     (lo_cout),
        .zout     (lo_z),
        .peer_out (lo_peer),
        .n        (lo_n),
        .v        (lo_v)
    );

    split_alu_slice #(.HIGH(1'b1)) u_hi (
        .a        (reg_a[BYTE_W-1:NIB_W]),
        .b        (b_in[BYTE_W-1:NIB_W]),
        .fn       (ctrl.fn),
        .dec      (dec_on),
        .v_en     (ctrl.v_en & ~dec_on),
        .bit_mode (ctrl.bit_mode),
        .cin      (hi_cin),
        .zin      (lo_z),
        .y        (hi_y),
        .cout     (hi_cout),
        .zout     (hi_z),
        .peer_out (hi_peer),
        .n        (hi_n),
        .v        (hi_v)
    );

    // Purpose: final carry source per operation.
    always_comb begin
        case (ctrl.co_src)
            CO_HIGH: c_next = hi_cout;
            CO_LOW:  c_next = lo_cout;
            default: c_next = carry_in;
        endcase
    end

    assign d_pack = {hi_y, lo_y, c_next, hi_z, hi_v | lo_v, hi_n | lo_n};

    split_alu_flop #(.W(REG_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (strobe),
        .d     (d_pack),
        .q     (q_pack)
    );

    // Purpose: unpack the registered word onto the ports.
    assign {result, flag_c, flag_z, flag_v, flag_n} = q_pack;

endmodule

// File: rtl/split_alu_chk.sv
// Checker for split_alu: temporal properties over ports only.
// Attached to every split_alu instance by the bind at the end.
module split_alu_chk
    import split_alu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              strobe,
    input logic [3:0]        op,
    input logic              carry_in,
    input logic [BYTE_W-1:0] reg_a,
    input logic [BYTE_W-1:0] operand_b,
    input logic [BYTE_W-1:0] result,
    input logic              flag_c,
    input logic              flag_z,
    input logic              flag_v,
    input logic              flag_n
);

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> ($stable(result) && $stable(flag_c) && $stable(flag_z)
                     && $stable(flag_v) && $stable(flag_n)));

    // R12
    zero_whole_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && op != OP_BIT) |=> (flag_z == (result == '0)));

    // R13
    neg_from_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && op != OP_BIT) |=> (flag_n == result[BYTE_W-1]));

    // R8
    cmp_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && op == OP_CMP) |=> (flag_c == ($past(reg_a) >= $past(operand_b))));

    // R6
    logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && (op == OP_AND || op == OP_ORA || op == OP_EOR))
        |=> (flag_c == $past(carry_in) && !flag_v));

    // R7
    bit_test_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && op == OP_BIT)
        |=> (flag_n == $past(operand_b[BYTE_W-1]) && flag_v == $past(operand_b[BYTE_W-2])));

endmodule

bind split_alu split_alu_chk u_split_alu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .op        (op),
    .carry_in  (carry_in),
    .reg_a     (reg_a),
    .operand_b (operand_b),
    .result    (result),
    .flag_c    (flag_c),
    .flag_z    (flag_z),
    .flag_v    (flag_v),
    .flag_n    (flag_n)
);

// File: tb/split_alu_bench.sv
// Bench for split_alu: a vector table walked by one loop, random
// vectors against a behavioural model, then reset and hold tests.
module split_alu_bench;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 26;
    localparam int  NRAND = 400;

    // {op, dec, cin, a, b, result, {C,Z,V,N}}
    localparam logic [33:0] VEC [NVEC] = '{
        {4'd0,  1'b0, 1'b0, 8'h50, 8'h50, 8'hA0, 4'b0011}, // R3 overflow
        {4'd0,  1'b0, 1'b0, 8'hFF, 8'h01, 8'h00, 4'b1100}, // R3 carry, R12
        {4'd0,  1'b0, 1'b1, 8'h01, 8'h01, 8'h03, 4'b0000}, // R3 carry in
        {4'd1,  1'b0, 1'b1, 8'h50, 8'hF0, 8'h60, 4'b0000}, // R4 borrow
        {4'd1,  1'b0, 1'b1, 8'h50, 8'hB0, 8'hA0, 4'b0011}, // R4 overflow
        {4'd1,  1'b0, 1'b0, 8'h05, 8'h03, 8'h01, 4'b1000}, // R4 borrow in
        {4'd0,  1'b1, 1'b0, 8'h19, 8'h28, 8'h47, 4'b0000}, // R5 low adjust
        {4'd0,  1'b1, 1'b0, 8'h99, 8'h01, 8'h00, 4'b1100}, // R5 both adjust
        {4'd1,  1'b1, 1'b1, 8'h40, 8'h01, 8'h39, 4'b1000}, // R5 borrow
        {4'd1,  1'b1, 1'b1, 8'h00, 8'h01, 8'h99, 4'b0001}, // R5 wrap
        {4'd2,  1'b0, 1'b1, 8'hF0, 8'h3C, 8'h30, 4'b1000}, // R6 and
        {4'd3,  1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 4'b0100}, // R6 or
        {4'd4,  1'b1, 1'b0, 8'hAA, 8'hFF, 8'h55, 4'b0000}, // R6 eor, dec ignored
        {4'd5,  1'b0, 1'b0, 8'h0F, 8'hC0, 8'h00, 4'b0111}, // R7 bit test
        {4'd6,  1'b0, 1'b0, 8'h40, 8'h40, 8'h00, 4'b1100}, // R8 equal
        {4'd6,  1'b1, 1'b1, 8'h10, 8'h20, 8'hF0, 4'b0001}, // R8 less
        {4'd7,  1'b0, 1'b0, 8'h0F, 8'h00, 8'h10, 4'b0000}, // R9 inc cross
        {4'd7,  1'b0, 1'b1, 8'hFF, 8'h00, 8'h00, 4'b1100}, // R9 inc wrap
        {4'd8,  1'b0, 1'b0, 8'h10, 8'h00, 8'h0F, 4'b0000}, // R9 dec cross
        {4'd8,  1'b1, 1'b0, 8'h00, 8'h55, 8'hFF, 4'b0001}, // R9 dec wrap
        {4'd9,  1'b0, 1'b1, 8'h88, 8'h00, 8'h10, 4'b1000}, // R10 shift left
        {4'd11, 1'b0, 1'b1, 8'h08, 8'h00, 8'h11, 4'b0000}, // R10 rotate left
        {4'd10, 1'b0, 1'b1, 8'h11, 8'h00, 8'h08, 4'b1000}, // R11 shift right
        {4'd12, 1'b0, 1'b1, 8'h10, 8'h00, 8'h88, 4'b0001}, // R11 rotate right
        {4'd12, 1'b0, 1'b0, 8'h01, 8'h00, 8'h00, 4'b1100}, // R11 R12 to zero
        {4'd13, 1'b0, 1'b1, 8'h80, 8'h3C, 8'h80, 4'b1001}  // R13 pass
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe = 1'b0;
    logic [3:0] op = '0;
    logic       dec_mode = 1'b0;
    logic       carry_in = 1'b0;
    logic [7:0] reg_a = '0;
    logic [7:0] operand_b = '0;
    logic [7:0] result;
    logic       flag_c, flag_z, flag_v, flag_n;

    int checks = 0;
    int fails  = 0;

    split_alu u_split_alu (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .op(op),
        .dec_mode(dec_mode), .carry_in(carry_in), .reg_a(reg_a),
        .operand_b(operand_b), .result(result), .flag_c(flag_c),
        .flag_z(flag_z), .flag_v(flag_v), .flag_n(flag_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model: returns {result, C, Z, V, N}.
    function automatic logic [11:0] model(logic [3:0] o, logic d, logic c,
                                          logic [7:0] a, logic [7:0] b);
        logic [8:0] s;
        logic [7:0] r;
        logic       cf, vf, nf, zf;
        int         lo, hi, c1;
        r = a; cf = c; vf = 1'b0;
        case (o)
            4'd0: if (d) begin
                    lo = int'(a[3:0]) + int'(b[3:0]) + int'(c);
                    c1 = (lo > 9) ? 1 : 0; if (lo > 9) lo += 6;
                    hi = int'(a[7:4]) + int'(b[7:4]) + c1;
                    cf = (hi > 9); if (hi > 9) hi += 6;
                    r = {4'(hi), 4'(lo)};
                  end else begin
                    s = {1'b0, a} + {1'b0, b} + {8'd0, c};
                    r = s[7:0]; cf = s[8];
                    vf = (a[7] == b[7]) && (r[7] != a[7]);
                  end
            4'd1: if (d) begin
                    lo = int'(a[3:0]) - int'(b[3:0]) - (c ? 0 : 1);
                    c1 = (lo < 0) ? 0 : 1; if (lo < 0) lo -= 6;
                    hi = int'(a[7:4]) - int'(b[7:4]) - (1 - c1);
                    cf = !(hi < 0); if (hi < 0) hi -= 6;
                    r = {4'(hi & 15), 4'(lo & 15)};
                  end else begin
                    s = {1'b0, a} + {1'b0, ~b} + {8'd0, c};
                    r = s[7:0]; cf = s[8];
                    vf = (a[7] != b[7]) && (r[7] != a[7]);
                  end
            4'd2: r = a & b;
            4'd3: r = a | b;
            4'd4: r = a ^ b;
            4'd5: begin r = a & b; vf = b[6]; end
            4'd6: begin r = a - b; cf = (a >= b); end
            4'd7: r = a + 8'd1;
            4'd8: r = a - 8'd1;
            4'd9: begin r = {a[6:0], 1'b0}; cf = a[7]; end
            4'd11: begin r = {a[6:0], c}; cf = a[7]; end
            4'd10: begin r = {1'b0, a[7:1]}; cf = a[0]; end
            4'd12: begin r = {c, a[7:1]}; cf = a[0]; end
            default: r = a;
        endcase
        zf = (r == 8'd0);
        nf = (o == 4'd5) ? b[7] : r[7];
        return {r, cf, zf, vf, nf};
    endfunction

    // Purpose: present one operation with a strobe; outputs valid after it.
    task automatic run_op(input logic [3:0] o, input logic d, input logic c,
                          input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        op = o; dec_mode = d; carry_in = c; reg_a = a; operand_b = b;
        strobe = 1'b1;
        @(posedge clk);
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic check(input string req, input logic [11:0] got,
                         input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got res=%h CZVN=%b expected res=%h CZVN=%b",
                     req, got[11:4], got[3:0], exp[11:4], exp[3:0]);
        end
    endtask

    function automatic string req_of(logic [3:0] o, logic d);
        case (o)
            4'd0, 4'd1: return d ? "R5" : (o == 4'd0 ? "R3" : "R4");
            4'd2, 4'd3, 4'd4: return "R6";
            4'd5: return "R7";
            4'd6: return "R8";
            4'd7, 4'd8: return "R9";
            4'd9, 4'd11: return "R10";
            4'd10, 4'd12: return "R11";
            default: return "R13";
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [11:0] snap;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", {result, flag_c, flag_z, flag_v, flag_n}, 12'h000);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [33:0] v;
            v = VEC[i];
            run_op(v[33:30], v[29], v[28], v[27:20], v[19:12]);
            check(req_of(v[33:30], v[29]), {result, flag_c, flag_z, flag_v, flag_n},
                  v[11:0]);
            // R12 R13: table entries also cross-checked against the model
            check("R12", model(v[33:30], v[29], v[28], v[27:20], v[19:12]), v[11:0]);
        end

        for (int i = 0; i < NRAND; i++) begin
            logic [3:0] o;
            logic       d, c;
            logic [7:0] a, b;
            o = 4'($urandom % 16);
            d = 1'($urandom % 2);
            c = 1'($urandom % 2);
            if (d && (o == 4'd0 || o == 4'd1)) begin
                a = {4'($urandom % 10), 4'($urandom % 10)};
                b = {4'($urandom % 10), 4'($urandom % 10)};
            end else begin
                a = 8'($urandom);
                b = 8'($urandom);
            end
            run_op(o, d, c, a, b);
            check(req_of(o, d), {result, flag_c, flag_z, flag_v, flag_n},
                  model(o, d, c, a, b));
        end

        // R2: no strobe, inputs change, outputs hold
        run_op(4'd0, 1'b0, 1'b0, 8'h12, 8'h34);
        snap = {result, flag_c, flag_z, flag_v, flag_n};
        @(negedge clk);
        op = 4'd7; reg_a = 8'hFF; carry_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R2", {result, flag_c, flag_z, flag_v, flag_n}, snap);
        check("R2", snap, 12'h460);

        // R1: reset mid-run clears and wins over strobe
        @(negedge clk);
        rst_n = 1'b0; strobe = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", {result, flag_c, flag_z, flag_v, flag_n}, 12'h000);
        strobe = 1'b0; rst_n = 1'b1;

        // R12: zero low nibble alone does not raise Z
        run_op(4'd2, 1'b0, 1'b0, 8'hF0, 8'h10);
        check("R12", {result, flag_c, flag_z, flag_v, flag_n}, 12'h100);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule